// File: doc/BRIEF.md
# Wiper Position Counter with One-Hot Tap Decoder

This block holds the six-bit wiper position of one digitally controlled potentiometer and turns it into a one-hot select for the 64 tap switches along the resistor ladder. Tap 0 is the switch at the low terminal of the ladder. Tap 63 is the switch at the high terminal. Exactly one switch is closed at all times, so the wiper is never left floating and never shorts two taps.

The position changes in four ways:
- **Stored-setting recall.** On the first clock edge after reset the block takes the stored power-on setting from `dr0_val_i`. The position is volatile, so every reset discards the value in use before it.
- **Parallel transfer.** A data register is copied into the position with `par_load_i` and `par_val_i`.
- **Host write.** The host writes a new position through the serial path with `host_wr_i` and `host_val_i`. Only the low six bits of the data byte are used.
- **Single steps.** `step_up_i` and `step_dn_i` move the wiper one segment at a time. A step stops at either end of the ladder and never wraps.

The current position is on `pos_o` for readback. The tap select on `tap_sel_o` is registered and follows `pos_o` one clock later.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: `tap_sel_o` always has exactly one bit set. While `rst_ni` is low, `pos_o` is 0 and `tap_sel_o` has bit 0 set.
- R2: On the first rising clock edge after `rst_ni` goes high, `pos_o` takes `dr0_val_i`. Every other load and step input is ignored in that cycle.
- R3: When `par_load_i` is high in a cycle after the recall cycle, `pos_o` takes `par_val_i` at that edge. This load takes priority over a host write and over steps in the same cycle.
- R4: When `host_wr_i` is high and `par_load_i` is low, `pos_o` takes `host_val_i[5:0]` at that edge. `host_val_i[7:6]` are ignored, and the write takes priority over steps.
- R5: With no load active, `step_up_i` alone adds 1 to `pos_o` and `step_dn_i` alone subtracts 1, once per clock cycle the strobe is high.
- R6: An up step at position 63 and a down step at position 0 leave `pos_o` unchanged, with no wraparound.
- R7: When `step_up_i` and `step_dn_i` are high in the same cycle with no load, `pos_o` is unchanged.
- R8: `tap_sel_o` has only bit N set, where N is the value `pos_o` held one clock earlier. Bit 0 is the low-terminal tap and bit 63 is the high-terminal tap.
- R9: After a second reset, `pos_o` comes from `dr0_val_i` and not from the value held before that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dr0_val_i | input | 6 | Stored power-on setting, recalled after reset |
| par_load_i | input | 1 | Parallel transfer strobe from a data register |
| par_val_i | input | 6 | Data register value for parallel transfer |
| host_wr_i | input | 1 | Host write strobe on the serial path |
| host_val_i | input | 8 | Host data byte; bits 5:0 are the position |
| step_up_i | input | 1 | Step one segment toward the high terminal |
| step_dn_i | input | 1 | Step one segment toward the low terminal |
| pos_o | output | 6 | Current wiper position |
| tap_sel_o | output | 64 | Registered one-hot tap switch select |

## Verification
The bench holds a parallel load high across the recall cycle. A design with the wrong priority would take the data register value instead of the stored setting.

It drives steps at both ends of the ladder, where a wrapping counter would jump from 63 to 0 or from 0 to 63. It also pulses both step strobes together, where a design with a bias toward one direction would move.

It loads every position and checks the tap select one cycle late against the previous position. It does this at the load edge and again one clock later. A decoder that is combinational, misses a position or has more than one bit set fails these checks.

It writes a host byte with its top bits set, which a design that does not mask them would turn into a wrong position. It repeats the reset, where a design that keeps the old position would fail R9.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_BOOT,
    SRC_PAR,
    SRC_SER,
    SRC_STEP
  } wiper_src_e;
endpackage

// File: rtl/wiper_step_sat.sv
module wiper_step_sat #(
  parameter int POS_W = 6
) (
  input  logic [POS_W-1:0] cur_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic             step_en_o,
  output logic [POS_W-1:0] nxt_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic go_up, go_dn;

  // opposing strobes cancel; ends saturate
  assign go_up = up_i && !dn_i && (cur_i != POS_MAX);
  assign go_dn = dn_i && !up_i && (cur_i != POS_MIN);

  assign step_en_o = go_up || go_dn;

  always_comb begin
    nxt_o = cur_i;
    if (go_up) nxt_o = cur_i + POS_W'(1);
    else if (go_dn) nxt_o = cur_i - POS_W'(1);
  end
endmodule

// File: rtl/wiper_src_arb.sv
module wiper_src_arb
  import wiper_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             boot_i,
  input  logic [POS_W-1:0] boot_val_i,
  input  logic             par_i,
  input  logic [POS_W-1:0] par_val_i,
  input  logic             ser_i,
  input  logic [POS_W-1:0] ser_val_i,
  input  logic             step_i,
  input  logic [POS_W-1:0] step_val_i,
  input  logic [POS_W-1:0] cur_i,
  output logic             load_o,
  output logic [POS_W-1:0] nxt_o
);
  wiper_src_e src;

  always_comb begin
    if (boot_i)      src = SRC_BOOT;
    else if (par_i)  src = SRC_PAR;
    else if (ser_i)  src = SRC_SER;
    else if (step_i) src = SRC_STEP;
    else             src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_BOOT: nxt_o = boot_val_i;
      SRC_PAR:  nxt_o = par_val_i;
      SRC_SER:  nxt_o = ser_val_i;
      SRC_STEP: nxt_o = step_val_i;
      default:  nxt_o = cur_i;
    endcase
  end

  assign load_o = (src != SRC_HOLD);
endmodule

// File: rtl/wiper_tap_dec.sv
module wiper_tap_dec #(
  parameter int POS_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [POS_W-1:0]     pos_i,
  output logic [(1<<POS_W)-1:0] tap_o
);
  localparam int TAPS = 1 << POS_W;

  logic [TAPS-1:0] tap_d;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_d[t] = (pos_i == POS_W'(t));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_o <= TAPS'(1);
    else         tap_o <= tap_d;
  end
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl #(
  parameter int POS_W  = 6,
  parameter int DATA_W = 8,
  localparam int TAPS  = 1 << POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POS_W-1:0]  dr0_val_i,
  input  logic              par_load_i,
  input  logic [POS_W-1:0]  par_val_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_val_i,
  input  logic              step_up_i,
  input  logic              step_dn_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [TAPS-1:0]   tap_sel_o
);
  logic             boot_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] step_nxt;
  logic             step_en;
  logic             load;
  logic             unused_host_hi;

  assign unused_host_hi = ^host_val_i[DATA_W-1:POS_W];

  wiper_step_sat #(.POS_W(POS_W)) u_step (
    .cur_i     (pos_q),
    .up_i      (step_up_i),
    .dn_i      (step_dn_i),
    .step_en_o (step_en),
    .nxt_o     (step_nxt)
  );

  wiper_src_arb #(.POS_W(POS_W)) u_arb (
    .boot_i     (boot_q),
    .boot_val_i (dr0_val_i),
    .par_i      (par_load_i),
    .par_val_i  (par_val_i),
    .ser_i      (host_wr_i),
    .ser_val_i  (host_val_i[POS_W-1:0]),
    .step_i     (step_en),
    .step_val_i (step_nxt),
    .cur_i      (pos_q),
    .load_o     (load),
    .nxt_o      (pos_d)
  );

  // recall of stored setting on first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else         boot_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pos_q <= '0;
    else if (load) pos_q <= pos_d;
  end

  wiper_tap_dec #(.POS_W(POS_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (pos_q),
    .tap_o  (tap_sel_o)
  );

  assign pos_o = pos_q;
endmodule

// File: rtl/wiper_tap_ctrl_chk.sv
module wiper_tap_ctrl_chk #(
  parameter int POS_W  = 6,
  parameter int DATA_W = 8,
  localparam int TAPS  = 1 << POS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              boot_i,
  input logic [POS_W-1:0]  dr0_val_i,
  input logic              par_load_i,
  input logic [POS_W-1:0]  par_val_i,
  input logic              host_wr_i,
  input logic [DATA_W-1:0] host_val_i,
  input logic              step_up_i,
  input logic              step_dn_i,
  input logic [POS_W-1:0]  pos_o,
  input logic [TAPS-1:0]   tap_sel_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic no_load;
  assign no_load = !boot_i && !par_load_i && !host_wr_i;

  assert_tap_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_sel_o) == 1);

  assert_boot_recall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_i |=> pos_o == $past(dr0_val_i));

  assert_par_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_i && par_load_i) |=> pos_o == $past(par_val_i));

  assert_host_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_i && !par_load_i && host_wr_i) |=> pos_o == $past(host_val_i[POS_W-1:0]));

  assert_step_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && step_up_i && !step_dn_i && pos_o != POS_MAX)
      |=> pos_o == $past(pos_o) + POS_W'(1));

  assert_step_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && step_dn_i && !step_up_i && pos_o != '0)
      |=> pos_o == $past(pos_o) - POS_W'(1));

  assert_sat_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && step_up_i && pos_o == POS_MAX) |=> $stable(pos_o));

  assert_sat_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && step_dn_i && pos_o == '0) |=> $stable(pos_o));

  assert_step_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && step_up_i && step_dn_i) |=> $stable(pos_o));

  assert_tap_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tap_sel_o == (TAPS'(1) << $past(pos_o)));
endmodule

bind wiper_tap_ctrl wiper_tap_ctrl_chk #(.POS_W(POS_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boot_i     (boot_q),
  .dr0_val_i  (dr0_val_i),
  .par_load_i (par_load_i),
  .par_val_i  (par_val_i),
  .host_wr_i  (host_wr_i),
  .host_val_i (host_val_i),
  .step_up_i  (step_up_i),
  .step_dn_i  (step_dn_i),
  .pos_o      (pos_o),
  .tap_sel_o  (tap_sel_o)
);

// File: tb/wiper_tap_ctrl_test.sv
module wiper_tap_ctrl_test;
  localparam int POS_W  = 6;
  localparam int DATA_W = 8;
  localparam int TAPS   = 1 << POS_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [POS_W-1:0]  dr0_val_i = '0;
  logic              par_load_i = 1'b0;
  logic [POS_W-1:0]  par_val_i = '0;
  logic              host_wr_i = 1'b0;
  logic [DATA_W-1:0] host_val_i = '0;
  logic              step_up_i = 1'b0;
  logic              step_dn_i = 1'b0;
  logic [POS_W-1:0]  pos_o;
  logic [TAPS-1:0]   tap_sel_o;

  int checks = 0;
  int errors = 0;

  wiper_tap_ctrl #(.POS_W(POS_W), .DATA_W(DATA_W)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dr0_val_i  (dr0_val_i),
    .par_load_i (par_load_i),
    .par_val_i  (par_val_i),
    .host_wr_i  (host_wr_i),
    .host_val_i (host_val_i),
    .step_up_i  (step_up_i),
    .step_dn_i  (step_dn_i),
    .pos_o      (pos_o),
    .tap_sel_o  (tap_sel_o)
  );

  always #10 clk_i = ~clk_i;

  // advance one edge; sample and drive 2 ns after it
  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk_pos(string req, logic [POS_W-1:0] exp);
    checks++;
    if (pos_o !== exp) begin
      errors++;
      $display("FAIL %s pos act=%0d exp=%0d", req, pos_o, exp);
    end
  endtask

  task automatic chk_tap(string req, int exp_idx);
    logic [TAPS-1:0] exp;
    exp = TAPS'(1) << exp_idx;
    checks++;
    if (tap_sel_o !== exp) begin
      errors++;
      $display("FAIL %s tap act=%h exp=%h", req, tap_sel_o, exp);
    end
  endtask

  task automatic idle();
    par_load_i = 1'b0;
    host_wr_i  = 1'b0;
    step_up_i  = 1'b0;
    step_dn_i  = 1'b0;
  endtask

  task automatic set_pos(logic [POS_W-1:0] v);
    par_load_i = 1'b1;
    par_val_i  = v;
    tick();
    idle();
    tick();
  endtask

  task automatic t_reset_boot();
    rst_ni = 1'b0;
    dr0_val_i = 6'h2A;
    par_load_i = 1'b1;
    par_val_i = 6'h05;
    tick();
    tick();
    chk_pos("R1 reset", 6'h00);
    chk_tap("R1 reset", 0);
    rst_ni = 1'b1;
    tick();
    chk_pos("R2 boot beats parallel", 6'h2A);
    chk_tap("R8 tap lags boot", 0);
    tick();
    chk_pos("R3 parallel after boot", 6'h05);
    chk_tap("R8 tap follows boot", 42);
    idle();
    tick();
    chk_tap("R8 tap follows parallel", 5);
  endtask

  task automatic t_priority();
    par_load_i = 1'b1; par_val_i = 6'h11;
    host_wr_i = 1'b1; host_val_i = 8'h22;
    step_up_i = 1'b1;
    tick();
    chk_pos("R3 parallel beats host and step", 6'h11);
    par_load_i = 1'b0;
    host_val_i = 8'h33;
    tick();
    chk_pos("R4 host beats step", 6'h33);
    idle();
    tick();
  endtask

  task automatic t_host_mask();
    host_wr_i = 1'b1; host_val_i = 8'hC7;
    tick();
    idle();
    chk_pos("R4 upper bits ignored", 6'h07);
    tick();
    chk_tap("R4 tap after masked write", 7);
  endtask

  task automatic t_steps();
    set_pos(6'd20);
    step_up_i = 1'b1;
    tick(); chk_pos("R5 up 1", 6'd21);
    tick(); chk_pos("R5 up 2", 6'd22);
    tick(); chk_pos("R5 up 3", 6'd23);
    step_up_i = 1'b0; step_dn_i = 1'b1;
    tick(); chk_pos("R5 down 1", 6'd22);
    tick(); chk_pos("R5 down 2", 6'd21);
    idle();
    tick(); chk_pos("R5 hold", 6'd21);
    chk_tap("R8 tap after steps", 21);
  endtask

  task automatic t_saturate();
    set_pos(6'd62);
    step_up_i = 1'b1;
    tick(); chk_pos("R6 reach top", 6'd63);
    tick(); chk_pos("R6 top hold", 6'd63);
    tick(); chk_pos("R6 top hold again", 6'd63);
    idle();
    tick(); chk_tap("R6 top tap", 63);
    set_pos(6'd1);
    step_dn_i = 1'b1;
    tick(); chk_pos("R6 reach bottom", 6'd0);
    tick(); chk_pos("R6 bottom hold", 6'd0);
    idle();
    tick(); chk_tap("R6 bottom tap", 0);
  endtask

  task automatic t_cancel();
    set_pos(6'd40);
    step_up_i = 1'b1; step_dn_i = 1'b1;
    tick(); chk_pos("R7 both strobes", 6'd40);
    tick(); chk_pos("R7 both strobes again", 6'd40);
    idle();
    set_pos(6'd63);
    step_up_i = 1'b1; step_dn_i = 1'b1;
    tick(); chk_pos("R7 both strobes at top", 6'd63);
    idle();
    tick();
  endtask

  task automatic t_sweep();
    int prev;
    prev = int'(pos_o);
    for (int v = 0; v < TAPS; v++) begin
      par_load_i = 1'b1;
      par_val_i = POS_W'(TAPS - 1 - v);
      tick();
      chk_pos("R3 sweep load", POS_W'(TAPS - 1 - v));
      chk_tap("R8 sweep lag", prev);
      prev = TAPS - 1 - v;
    end
    idle();
    tick();
    chk_tap("R1 sweep final", 0);
  endtask

  task automatic t_reboot();
    set_pos(6'd50);
    rst_ni = 1'b0;
    dr0_val_i = 6'h13;
    tick();
    chk_pos("R9 in reset", 6'd0);
    rst_ni = 1'b1;
    tick();
    chk_pos("R9 recall after reset", 6'h13);
    tick();
    chk_tap("R9 tap after recall", 19);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_boot();
    t_priority();
    t_host_mask();
    t_steps();
    t_saturate();
    t_cancel();
    t_sweep();
    t_reboot();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule